// File: doc/BRIEF.md
# One-Time-Programmable Word Programming Sequencer

This block programs a single 32-bit word of a one-time-programmable fuse array through a small register port. Software first writes the control register. That write carries the target word index and a 16-bit unlock key. Software then writes the data register, and this second write launches the program cycle. The sequencer reads the word's present fuse contents and clears from the new data every bit that is already blown. It then walks the data register one bit per step, shifting it right with zero fill. Each set bit is burnt with a strobe pulse that has a relax gap on both sides. The fuse array is modelled inside the block as a register array. A side look port lets the array be observed.

Once a cycle ends, the block waits a fixed settle window before it will accept another program request. Requests that break the rules do not touch the array and set an error flag. The rule-breaking cases are: a request with no unlock key, a request during a cycle or during the settle window, a request while the error flag is set, and a request to a locked word. The flag stays set until software clears it.

A banked variant (parameter `BANKED=1`) has four data registers. In that variant the index field selects a bank of four words, and only the write to the first data register launches the cycle, which programs all four words in turn.

Top module: `otp_word_prog`

## Requirements
- R1: A control write (offset 0x00) loads the word index from bits 6:0, and it arms the unlock only if bits 31:16 equal 0x3E77. Writing 1 in bit 9 clears ERROR. A control read returns the index in bits 6:0, BUSY in bit 8, ERROR in bit 9, the settle flag in bit 10, and 0x3E77 in bits 31:16 while the unlock is armed (zero otherwise). The reset read value is 0.
- R2: A write to data0 (offset 0x20) while the unlock is armed, the block is idle outside the settle window, ERROR is clear and the word is not locked starts a cycle, and `busy` is high from the next cycle. Every data0 write disarms the unlock, so a second cycle needs a fresh control write.
- R3: Only bits set in the new data and clear in the stored word are programmed. After the cycle the word equals old OR new.
- R4: The timing register (offset 0x10) holds the strobe length in bits 11:0, the relax length in bits 15:12 and a read strobe length in bits 21:16. It resets to 0x00021003 and is sampled when a cycle starts. A cycle keeps `busy` high for 33 + n·(2·(RELAX+1) + STROBE+1) cycles per word, where n is the number of bits that get programmed.
- R5: The word index is latched at start. Control writes made during the cycle do not redirect it.
- R6: During the cycle the data register shifts right with zero fill and reads 0 when the cycle ends. A data write during the cycle is ignored and sets ERROR.
- R7: A request to a word at or above index `LOCK_FIRST` sets ERROR, never raises `busy`, and leaves the word unchanged.
- R8: A data0 write without an armed unlock sets ERROR and starts nothing.
- R9: After `busy` falls, `settle` is high for `GAP_CYCLES` cycles. A request made in that window is ignored and sets ERROR.
- R10: While ERROR is set, a request starts nothing, even if the unlock is armed.
- R11: In banked mode the index selects bank b. Data register k (offsets 0x20, 0x30, 0x40, 0x50 for k = 0..3) programs word 4b+k, and writing registers 1 to 3 stores data without starting a cycle.
- R12: `bus_ready` is always high, so every transfer with `bus_valid` completes in its own cycle. Read data is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register transfer request |
| bus_ready | output | 1 | Transfer accepted (constant high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with the transfer |
| busy | output | 1 | Program cycle in progress |
| error | output | 1 | Sticky rule-violation flag |
| settle | output | 1 | Post-cycle settle window active |
| look_addr | input | ADDR_W | Fuse word to observe |
| look_data | output | 32 | Contents of the observed fuse word |

## Verification
The bench builds two instances. The first is a single-word instance with a 12-cycle settle window and a short reset timing, so every program cycle lasts well under a hundred clocks, and a behavioural model checks its busy, settle and error outputs on every clock. That short timing brings the masking arithmetic, the rejection rules and a reprogrammed timing register into reach in a few thousand cycles. The second is a banked instance, which shows the four-word layout and that a write to data1 does not launch a cycle.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  localparam logic [7:0]  OFF_CTRL   = 8'h00;
  localparam logic [7:0]  OFF_TIMING = 8'h10;
  localparam logic [7:0]  OFF_DATA0  = 8'h20;
  localparam logic [7:0]  DATA_STEP  = 8'h10;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam int          ERR_CLR_BIT = 9;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LOAD, SQ_STEP, SQ_PRE, SQ_STRB, SQ_POST, SQ_GAP
  } seq_state_t;

  typedef struct packed {
    logic [5:0]  sread;
    logic [3:0]  relax;
    logic [11:0] sprog;
  } otp_timing_t;
endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int NWORDS     = 128,
  parameter int NDATA      = 1,
  parameter int LOCK_FIRST = 120,
  parameter logic [11:0] SPROG_RST = 12'd3,
  parameter logic [3:0]  RELAX_RST = 4'd1,
  parameter logic [5:0]  SREAD_RST = 6'd2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc,
  input  logic                        wr,
  input  logic [7:0]                  addr,
  input  logic [31:0]                 wdata,
  input  logic                        busy,
  input  logic                        settle,
  input  logic [NDATA-1:0][31:0]      dregs,
  output logic [31:0]                 rdata,
  output logic                        error,
  output logic [ADDR_W-1:0]           ctrl_addr,
  output otp_timing_t                 timing,
  output logic                        start,
  output logic [NDATA-1:0]            data_we
);
  localparam int NBANK  = NWORDS / NDATA;
  localparam int BANK_W = $clog2(NBANK);

  logic armed;
  logic hit_ctrl, hit_time, trigger, ok_go, locked;
  logic [NDATA-1:0] hit_data;
  logic [BANK_W-1:0] bsel;
  int last_word;

  assign hit_ctrl = acc && wr && (addr == OFF_CTRL);
  assign hit_time = acc && wr && (addr == OFF_TIMING);

  genvar k;
  generate
    for (k = 0; k < NDATA; k++) begin : g_hit
      assign hit_data[k] = acc && wr && (addr == OFF_DATA0 + 8'(k) * DATA_STEP);
      assign data_we[k]  = hit_data[k] && !busy;
    end
  endgenerate

  assign bsel = ctrl_addr[BANK_W-1:0];
  always_comb begin
    last_word = int'(bsel) * NDATA + NDATA - 1;
    locked    = (last_word >= LOCK_FIRST);
  end

  assign trigger = hit_data[0];
  assign ok_go   = armed && !busy && !settle && !error && !locked;
  assign start   = trigger && ok_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      error     <= 1'b0;
      ctrl_addr <= '0;
      timing    <= '{sread: SREAD_RST, relax: RELAX_RST, sprog: SPROG_RST};
    end else begin
      if (hit_ctrl) begin
        ctrl_addr <= wdata[ADDR_W-1:0];
        armed     <= (wdata[31:16] == UNLOCK_KEY);
        if (wdata[ERR_CLR_BIT]) error <= 1'b0;
      end
      if (hit_time) timing <= wdata[21:0];
      if (trigger) armed <= 1'b0;
      if ((trigger && !ok_go) || ((|hit_data) && busy)) error <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFF_CTRL)
      rdata = {armed ? UNLOCK_KEY : 16'h0, 5'b0, settle, error, busy, 8'(ctrl_addr)};
    else if (addr == OFF_TIMING)
      rdata = {10'b0, timing};
    else
      for (int i = 0; i < NDATA; i++)
        if (addr == OFF_DATA0 + 8'(i) * DATA_STEP) rdata = dregs[i];
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R8
  no_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger && !armed && !busy |=> error && !busy);
  // R10
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger && error && !busy |=> error && !busy);
endmodule

// File: rtl/otp_data_bank.sv
module otp_data_bank #(
  parameter int NDATA = 1,
  parameter int IDX_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NDATA-1:0]       we,
  input  logic [31:0]            wdata,
  input  logic                   load,
  input  logic                   shift,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            fuse_word,
  output logic [NDATA-1:0][31:0] dregs,
  output logic                   lsb
);
  logic [31:0] sel_now;

  genvar k;
  generate
    for (k = 0; k < NDATA; k++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                               dregs[k] <= '0;
        else if (we[k])                           dregs[k] <= wdata;
        else if (load && idx == IDX_W'(k))        dregs[k] <= dregs[k] & ~fuse_word;
        else if (shift && idx == IDX_W'(k))       dregs[k] <= {1'b0, dregs[k][31:1]};
      end
    end
    if (NDATA == 1) begin : g_one
      assign sel_now = dregs[0];
    end else begin : g_many
      assign sel_now = dregs[idx];
    end
  endgenerate

  assign lsb = sel_now[0];

  // R3
  mask_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((sel_now & $past(fuse_word)) == 32'h0));
  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> !sel_now[31]);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int NDATA      = 1,
  parameter int IDX_W      = 1,
  parameter int GAP_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ctrl_addr,
  input  otp_timing_t       timing,
  input  logic              lsb,
  output logic              busy,
  output logic              settle,
  output logic              load,
  output logic              shift,
  output logic [IDX_W-1:0]  idx,
  output logic              fuse_we,
  output logic [ADDR_W-1:0] word_addr,
  output logic [4:0]        fuse_bit
);
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
  localparam int IDXB   = $clog2(NDATA);
  localparam int BANK_W = ADDR_W - IDXB;

  seq_state_t  state;
  otp_timing_t tim;
  logic [ADDR_W-1:0] lat_addr;
  logic [4:0]        bitn;
  logic [11:0]       cnt;
  logic [GAP_W-1:0]  gapc;
  logic relax_end, strobe_end, last_bit, last_word;

  generate
    if (NDATA == 1) begin : g_flat
      assign word_addr = lat_addr;
    end else begin : g_bank
      assign word_addr = {lat_addr[BANK_W-1:0], idx[IDXB-1:0]};
    end
  endgenerate

  assign relax_end  = (cnt == {8'b0, tim.relax});
  assign strobe_end = (cnt == tim.sprog);
  assign last_bit   = (bitn == 5'd31);
  assign last_word  = (idx == IDX_W'(NDATA - 1));

  assign busy     = (state != SQ_IDLE) && (state != SQ_GAP);
  assign settle   = (state == SQ_GAP);
  assign load     = (state == SQ_LOAD);
  assign fuse_we  = (state == SQ_STRB) && strobe_end;
  assign fuse_bit = bitn;
  assign shift    = ((state == SQ_STEP) && !lsb) || ((state == SQ_POST) && relax_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      tim      <= '0;
      lat_addr <= '0;
      bitn     <= '0;
      cnt      <= '0;
      gapc     <= '0;
      idx      <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          lat_addr <= ctrl_addr;
          tim      <= timing;
          idx      <= '0;
          state    <= SQ_LOAD;
        end
        SQ_LOAD: begin
          bitn  <= '0;
          state <= SQ_STEP;
        end
        SQ_STEP, SQ_POST: begin
          if (state == SQ_STEP && lsb) begin
            cnt   <= '0;
            state <= SQ_PRE;
          end else if (state == SQ_POST && !relax_end) begin
            cnt <= cnt + 12'd1;
          end else if (!last_bit) begin
            bitn  <= bitn + 5'd1;
            state <= SQ_STEP;
          end else if (!last_word) begin
            idx   <= idx + IDX_W'(1);
            state <= SQ_LOAD;
          end else begin
            gapc  <= '0;
            state <= SQ_GAP;
          end
        end
        SQ_PRE: begin
          if (relax_end) begin
            cnt   <= '0;
            state <= SQ_STRB;
          end else cnt <= cnt + 12'd1;
        end
        SQ_STRB: begin
          if (strobe_end) begin
            cnt   <= '0;
            state <= SQ_POST;
          end else cnt <= cnt + 12'd1;
        end
        SQ_GAP: begin
          if (gapc == GAP_W'(GAP_CYCLES - 1)) state <= SQ_IDLE;
          else gapc <= gapc + GAP_W'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R9
  settle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> settle);
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(lat_addr));
  // R4
  burn_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_we |-> busy && !settle);
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int NWORDS = 128,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [4:0]        wbit,
  output logic [31:0]       rword,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [31:0]       look_data
);
  logic [31:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr][wbit] <= 1'b1;
    end
  end

  assign rword     = mem[waddr];
  assign look_data = mem[look_addr];
endmodule

// File: rtl/otp_word_prog.sv
module otp_word_prog
  import otp_seq_pkg::*;
#(
  parameter int NWORDS     = 128,
  parameter int BANKED     = 0,
  parameter int LOCK_FIRST = 120,
  parameter int GAP_CYCLES = 400,
  parameter logic [11:0] SPROG_RST = 12'd3,
  parameter logic [3:0]  RELAX_RST = 4'd1,
  parameter logic [5:0]  SREAD_RST = 6'd2,
  localparam int ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              error,
  output logic              settle,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [31:0]       look_data
);
  localparam int NDATA = (BANKED != 0) ? 4 : 1;
  localparam int IDX_W = (NDATA > 1) ? $clog2(NDATA) : 1;

  logic acc, start, load, shift, lsb, fuse_we;
  logic [NDATA-1:0]       data_we;
  logic [NDATA-1:0][31:0] dregs;
  logic [ADDR_W-1:0]      ctrl_addr, word_addr;
  logic [IDX_W-1:0]       idx;
  logic [4:0]             fuse_bit;
  logic [31:0]            fuse_word;
  otp_timing_t            timing;

  assign bus_ready = 1'b1;
  assign acc       = bus_valid && bus_ready;

  otp_ctrl_regs #(
    .ADDR_W(ADDR_W), .NWORDS(NWORDS), .NDATA(NDATA), .LOCK_FIRST(LOCK_FIRST),
    .SPROG_RST(SPROG_RST), .RELAX_RST(RELAX_RST), .SREAD_RST(SREAD_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(bus_write), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy), .settle(settle), .dregs(dregs),
    .rdata(bus_rdata), .error(error), .ctrl_addr(ctrl_addr), .timing(timing),
    .start(start), .data_we(data_we)
  );

  otp_data_bank #(.NDATA(NDATA), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n), .we(data_we), .wdata(bus_wdata), .load(load),
    .shift(shift), .idx(idx), .fuse_word(fuse_word), .dregs(dregs), .lsb(lsb)
  );

  otp_prog_seq #(
    .ADDR_W(ADDR_W), .NDATA(NDATA), .IDX_W(IDX_W), .GAP_CYCLES(GAP_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_addr(ctrl_addr),
    .timing(timing), .lsb(lsb), .busy(busy), .settle(settle), .load(load),
    .shift(shift), .idx(idx), .fuse_we(fuse_we), .word_addr(word_addr),
    .fuse_bit(fuse_bit)
  );

  otp_fuse_array #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_fuse (
    .clk(clk), .rst_n(rst_n), .we(fuse_we), .waddr(word_addr), .wbit(fuse_bit),
    .rword(fuse_word), .look_addr(look_addr), .look_data(look_data)
  );
endmodule

// File: tb/otp_word_prog_tb_top.sv
module otp_word_prog_tb_top;
  localparam int GAP = 12;
  localparam logic [31:0] KEY = 32'h3E77_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic iv = 0, iw = 0; logic [7:0] ia = 0; logic [31:0] id = 0;
  logic bv = 0, bw = 0; logic [7:0] ba = 0; logic [31:0] bd = 0;
  logic [31:0] irdata, brdata, ilook, blook;
  logic [6:0]  ilook_a = 0, blook_a = 0;
  logic iready, bready, ibusy, berr, bbusy, ierr, iset, bset;

  int checks = 0, errors = 0;

  otp_word_prog #(.BANKED(0), .GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(iv), .bus_ready(iready), .bus_write(iw),
    .bus_addr(ia), .bus_wdata(id), .bus_rdata(irdata), .busy(ibusy), .error(ierr),
    .settle(iset), .look_addr(ilook_a), .look_data(ilook));

  otp_word_prog #(.BANKED(1), .GAP_CYCLES(GAP)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_ready(bready), .bus_write(bw),
    .bus_addr(ba), .bus_wdata(bd), .bus_rdata(brdata), .busy(bbusy), .error(berr),
    .settle(bset), .look_addr(blook_a), .look_data(blook));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model of the single-word instance
  int m_busy_left = 0, m_gap_left = 0;
  logic m_err = 0, m_armed = 0, model_on = 0;
  logic [6:0] m_addr = 0;
  int m_relax = 1, m_sprog = 3;
  logic [31:0] m_fuse [128];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy_left = 0; m_gap_left = 0; m_err = 0; m_armed = 0; m_addr = 0;
      m_relax = 1; m_sprog = 3;
      for (int i = 0; i < 128; i++) m_fuse[i] = 0;
    end else begin
      bit b, g;
      logic [31:0] nm;
      b = (m_busy_left > 0); g = (m_gap_left > 0);
      if (m_busy_left > 0) begin
        m_busy_left--;
        if (m_busy_left == 0) m_gap_left = GAP;
      end else if (m_gap_left > 0) m_gap_left--;
      if (iv && iw) begin
        if (ia == 8'h00) begin
          m_addr = id[6:0];
          m_armed = (id[31:16] == 16'h3E77);
          if (id[9]) m_err = 0;
        end else if (ia == 8'h10) begin
          m_sprog = int'(id[11:0]); m_relax = int'(id[15:12]);
        end else if (ia == 8'h20) begin
          if (b || g || m_err || !m_armed || m_addr >= 120) m_err = 1;
          else begin
            nm = id & ~m_fuse[m_addr];
            m_busy_left = 33 + $countones(nm) * (2 * m_relax + m_sprog + 3);
            m_fuse[m_addr] = m_fuse[m_addr] | id;
          end
          m_armed = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R4 busy vs model", {31'b0, ibusy}, {31'b0, m_busy_left > 0});
      chk("R9 settle vs model", {31'b0, iset}, {31'b0, m_gap_left > 0});
      chk("R8 error vs model", {31'b0, ierr}, {31'b0, m_err});
    end
  end

  task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
    if (!b) begin iv = 1; iw = 1; ia = a; id = d; end
    else    begin bv = 1; bw = 1; ba = a; bd = d; end
    @(posedge clk); @(negedge clk);
    iv = 0; iw = 0; bv = 0; bw = 0;
  endtask

  task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
    if (!b) begin iv = 1; iw = 0; ia = a; end
    else    begin bv = 1; bw = 0; ba = a; end
    #1 d = b ? brdata : irdata;
    @(posedge clk); @(negedge clk);
    iv = 0; bv = 0;
  endtask

  task automatic look(input bit b, input logic [6:0] a, output logic [31:0] d);
    if (!b) ilook_a = a; else blook_a = a;
    #1 d = b ? blook : ilook;
    @(negedge clk);
  endtask

  task automatic wait_idle(input bit b);
    if (!b) while (ibusy || iset) @(negedge clk);
    else    while (bbusy || bset) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_on = 1;

    // R1 / R4 / R12: reset state
    rd(0, 8'h00, r); chk("R1 ctrl reset", r, 32'h0);
    rd(0, 8'h10, r); chk("R4 timing reset", r, 32'h0002_1003);
    chk("R12 ready", {31'b0, iready}, 32'h1);

    // R1: arm and read back
    wr(0, 8'h00, KEY | 32'd3);
    rd(0, 8'h00, r); chk("R1 armed readback", r, 32'h3E77_0003);

    // R2 / R3 / R6: first program
    wr(0, 8'h20, 32'h0000_00A5);
    chk("R2 busy after start", {31'b0, ibusy}, 32'h1);
    wait_idle(0);
    look(0, 7'd3, r); chk("R3 word 3 first", r, 32'h0000_00A5);
    rd(0, 8'h20, r);  chk("R6 data reg drained", r, 32'h0);

    // R3: masked reprogram
    wr(0, 8'h00, KEY | 32'd3);
    wr(0, 8'h20, 32'h0000_00FF);
    wait_idle(0);
    look(0, 7'd3, r); chk("R3 word 3 merged", r, 32'h0000_00FF);

    // R8: no unlock key
    wr(0, 8'h00, 32'd5);
    wr(0, 8'h20, 32'h1);
    chk("R8 error set", {31'b0, ierr}, 32'h1);
    chk("R8 no busy", {31'b0, ibusy}, 32'h0);
    look(0, 7'd5, r); chk("R8 word 5 untouched", r, 32'h0);
    wr(0, 8'h00, 32'h200);
    chk("R1 error cleared", {31'b0, ierr}, 32'h0);

    // R7: locked word
    wr(0, 8'h00, KEY | 32'd125);
    wr(0, 8'h20, 32'hF);
    chk("R7 error", {31'b0, ierr}, 32'h1);
    chk("R7 no busy", {31'b0, ibusy}, 32'h0);
    look(0, 7'd125, r); chk("R7 word 125 untouched", r, 32'h0);
    wr(0, 8'h00, 32'h200);

    // R5 / R6: redirect and data write during the cycle
    wr(0, 8'h00, KEY | 32'd7);
    wr(0, 8'h20, 32'h3);
    wr(0, 8'h00, 32'd9);
    wr(0, 8'h20, 32'hFFFF);
    chk("R6 write while busy errors", {31'b0, ierr}, 32'h1);
    wait_idle(0);
    look(0, 7'd7, r); chk("R5 latched word", r, 32'h3);
    look(0, 7'd9, r); chk("R5 other word clean", r, 32'h0);
    wr(0, 8'h00, 32'h200);

    // R9: request in settle window
    wr(0, 8'h00, KEY | 32'd10);
    wr(0, 8'h20, 32'h1);
    while (ibusy) @(negedge clk);
    wr(0, 8'h00, KEY | 32'd10);
    wr(0, 8'h20, 32'h2);
    chk("R9 settle request errors", {31'b0, ierr}, 32'h1);
    wait_idle(0);
    look(0, 7'd10, r); chk("R9 word 10", r, 32'h1);
    wr(0, 8'h00, 32'h200);

    // R10: error blocks an armed request
    wr(0, 8'h20, 32'h1);
    wr(0, 8'h00, KEY | 32'd11);
    wr(0, 8'h20, 32'h1);
    chk("R10 no busy", {31'b0, ibusy}, 32'h0);
    repeat (5) @(negedge clk);
    look(0, 7'd11, r); chk("R10 word 11 untouched", r, 32'h0);
    wr(0, 8'h00, 32'h200);

    // R2: unlock is single use
    wr(0, 8'h00, KEY | 32'd12);
    wr(0, 8'h20, 32'h1);
    wait_idle(0);
    wr(0, 8'h20, 32'h2);
    chk("R2 re-arm needed", {31'b0, ierr}, 32'h1);
    look(0, 7'd12, r); chk("R2 word 12", r, 32'h1);
    wr(0, 8'h00, 32'h200);

    // R4: new timing, measured duration
    wr(0, 8'h10, 32'h0000_2005);
    wr(0, 8'h00, KEY | 32'd13);
    wr(0, 8'h20, 32'h0000_8001);
    n = 0;
    while (ibusy) begin n++; @(negedge clk); end
    chk("R4 busy length", 32'(n), 32'd57);
    wait_idle(0);
    look(0, 7'd13, r); chk("R4 word 13", r, 32'h0000_8001);

    // R11: banked instance
    wr(1, 8'h00, KEY | 32'd2);
    wr(1, 8'h30, 32'h3);
    chk("R11 data1 no start", {31'b0, bbusy}, 32'h0);
    wr(1, 8'h20, 32'h10);
    chk("R11 data0 starts", {31'b0, bbusy}, 32'h1);
    wait_idle(1);
    look(1, 7'd8, r);  chk("R11 word 8", r, 32'h10);
    look(1, 7'd9, r);  chk("R11 word 9", r, 32'h3);
    look(1, 7'd10, r); chk("R11 word 10", r, 32'h0);
    chk("R11 no error", {31'b0, berr}, 32'h0);

    model_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule